// File: doc/BRIEF.md
# Pixel Strobe Window Generator

This block produces the capture strobe for a pixel matrix. A discriminated hit is kept in the in-pixel memory only if the strobe is high at some point while that hit's binary pulse is high. In triggered operation, one external trigger opens one short window after a programmable delay. In continuous operation, windows repeat without any trigger. Each window has a programmable length and is followed by a short inactive gap. At a 40 MHz clock, a gap of about 100 ns is 4 cycles.

A single sequencer handles both modes. At the close of every window it raises a one-cycle readout-start pulse and advances a frame counter. In triggered mode, a trigger that arrives while the sequencer is busy is discarded and counted. The block also contains a small behavioural pixel-latch bank, so that capture can be observed at the ports.

Top module: `strobe_sequencer`

## Requirements
- R1: While the synchronous reset is high and in the cycle after it, `strobe` and `rd_start` are low, and `frame_cnt`, `drop_cnt` and `pix_latched` are zero.
- R2: With `mode_cont`=0, a trigger sampled while idle raises `strobe` `trig_dly`+1 cycles later. `strobe` then stays high for `win_len` cycles, and a `win_len` of 0 acts as 1.
- R3: With `mode_cont`=1, windows of `win_len` cycles repeat with no trigger. Consecutive windows are separated by `gap_len` low cycles, and a `gap_len` of 0 acts as 1.
- R4: `rd_start` is high for exactly one cycle, namely the first cycle after the last strobe cycle of a window.
- R5: `frame_cnt` increases by one, modulo its width, in the cycle `rd_start` is high, and is otherwise unchanged.
- R6: In triggered mode, a trigger sampled during the delay, the window or the following gap opens no window and increments `drop_cnt` by one.
- R7: In continuous mode, `trig` has no effect on the strobe and does not change `drop_cnt`.
- R8: Bit i of `pix_latched` is set after a window exactly when `hit_pulse[i]` was high in at least one strobe cycle of that window. The bank is overwritten when the next window opens and is held at all other times.
- R9: A change of `mode_cont` is acted on only at the end of a gap, or while idle. A running window and its gap always finish first.
- R10: In triggered mode, every window is followed by a gap of `gap_len` cycles (minimum 1) before a new trigger is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_cont | input | 1 | 1 = continuous windows, 0 = triggered windows |
| trig | input | 1 | External trigger, one cycle per trigger |
| win_len | input | WIN_W | Window length in cycles |
| gap_len | input | GAP_W | Gap length in cycles |
| trig_dly | input | DLY_W | Trigger-to-window delay in cycles |
| hit_pulse | input | NPIX | Discriminated hit pulse per modelled pixel |
| strobe | output | 1 | Capture strobe |
| rd_start | output | 1 | One-cycle pulse after each window closes |
| frame_cnt | output | FRAME_W | Count of closed windows |
| drop_cnt | output | DROP_W | Count of discarded triggers |
| pix_latched | output | NPIX | Behavioural pixel memory contents |

## Verification
Single triggered shots are run over a table of length, gap and delay settings, including zero length and zero delay. These shots separate delay counting from window counting and confirm the clamp to one cycle. Continuous runs with two different gap settings show whether the period is window plus gap, or whether a zero gap is stretched to one cycle. Triggers are placed inside the delay, inside the window, in the last gap cycle and in the first idle cycle; this shows exactly where acceptance begins again. Hit pulses placed before, inside, at the edge of and after a window show whether capture depends on strobe overlap alone.

// File: rtl/strb_pkg.sv
package strb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_OPEN  = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_e;

  // Programmed lengths of zero are treated as one cycle.
  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int unsigned widest(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/strb_window_fsm.sv
module strb_window_fsm
  import strb_pkg::*;
#(
  parameter int WIN_W = 8,
  parameter int GAP_W = 8,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_cont,
  input  logic             trig,
  input  logic [WIN_W-1:0] win_len,
  input  logic [GAP_W-1:0] gap_len,
  input  logic [DLY_W-1:0] trig_dly,
  output logic             strobe,
  output logic             win_close,
  output logic             trig_drop
);

  localparam int CNT_W = widest(WIN_W, GAP_W, DLY_W);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             cont_q;
  logic [CNT_W-1:0] win_m1;
  logic [CNT_W-1:0] gap_m1;
  logic             cnt_done;

  assign win_m1   = CNT_W'(at_least_one(32'(win_len)) - 1);
  assign gap_m1   = CNT_W'(at_least_one(32'(gap_len)) - 1);
  assign cnt_done = (cnt == '0);

  assign strobe    = (state == ST_OPEN);
  assign win_close = (state == ST_OPEN) && cnt_done;
  assign trig_drop = trig && (state != ST_IDLE) && !cont_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      cont_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (mode_cont) begin
            cont_q <= 1'b1;
            state  <= ST_OPEN;
            cnt    <= win_m1;
          end else if (trig) begin
            cont_q <= 1'b0;
            if (trig_dly == '0) begin
              state <= ST_OPEN;
              cnt   <= win_m1;
            end else begin
              state <= ST_DELAY;
              cnt   <= CNT_W'(trig_dly) - CNT_W'(1);
            end
          end
        end
        ST_DELAY: begin
          if (cnt_done) begin
            state <= ST_OPEN;
            cnt   <= win_m1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_OPEN: begin
          if (cnt_done) begin
            state <= ST_GAP;
            cnt   <= gap_m1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_GAP: begin
          if (cnt_done) begin
            if (mode_cont) begin
              cont_q <= 1'b1;
              state  <= ST_OPEN;
              cnt    <= win_m1;
            end else begin
              cont_q <= 1'b0;
              state  <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: the latched mode stays put until the gap ends
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && !(state == ST_GAP && cnt_done)) |=> $stable(cont_q));

  // R10: a closing window is always followed by a low cycle
  a_r10_gap_after_close: assert property (@(posedge clk) disable iff (rst)
    win_close |=> (state == ST_GAP));

endmodule

// File: rtl/strb_event_counters.sv
module strb_event_counters #(
  parameter int FRAME_W = 16,
  parameter int DROP_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               win_close,
  input  logic               trig_drop,
  output logic               rd_start,
  output logic [FRAME_W-1:0] frame_cnt,
  output logic [DROP_W-1:0]  drop_cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_start  <= 1'b0;
      frame_cnt <= '0;
      drop_cnt  <= '0;
    end else begin
      rd_start <= win_close;
      if (win_close) frame_cnt <= frame_cnt + FRAME_W'(1);
      if (trig_drop) drop_cnt  <= drop_cnt + DROP_W'(1);
    end
  end

  // R5: a close yields a readout pulse and one frame step
  a_r5_frame_step: assert property (@(posedge clk) disable iff (rst)
    win_close |=> (rd_start && frame_cnt == $past(frame_cnt) + 1'b1));

  // R6: every discarded trigger is counted once
  a_r6_drop_count: assert property (@(posedge clk) disable iff (rst)
    trig_drop |=> (drop_cnt == $past(drop_cnt) + 1'b1));

endmodule

// File: rtl/strb_pixel_latch.sv
module strb_pixel_latch #(
  parameter int NPIX = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strobe,
  input  logic [NPIX-1:0] hit_pulse,
  output logic [NPIX-1:0] held
);

  logic strobe_q;
  logic win_first;

  assign win_first = strobe && !strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  for (genvar i = 0; i < NPIX; i++) begin : g_pix
    always_ff @(posedge clk) begin
      if (rst)            held[i] <= 1'b0;
      else if (win_first) held[i] <= hit_pulse[i];
      else if (strobe)    held[i] <= held[i] | hit_pulse[i];
    end
  end

  // R8: memory contents cannot move outside a window
  a_r8_hold_outside: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(held));

endmodule

// File: rtl/strobe_sequencer.sv
module strobe_sequencer #(
  parameter int WIN_W   = 8,
  parameter int GAP_W   = 8,
  parameter int DLY_W   = 8,
  parameter int FRAME_W = 16,
  parameter int DROP_W  = 8,
  parameter int NPIX    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_cont,
  input  logic               trig,
  input  logic [WIN_W-1:0]   win_len,
  input  logic [GAP_W-1:0]   gap_len,
  input  logic [DLY_W-1:0]   trig_dly,
  input  logic [NPIX-1:0]    hit_pulse,
  output logic               strobe,
  output logic               rd_start,
  output logic [FRAME_W-1:0] frame_cnt,
  output logic [DROP_W-1:0]  drop_cnt,
  output logic [NPIX-1:0]    pix_latched
);

  logic win_close;
  logic trig_drop;

  strb_window_fsm #(.WIN_W(WIN_W), .GAP_W(GAP_W), .DLY_W(DLY_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .mode_cont (mode_cont),
    .trig      (trig),
    .win_len   (win_len),
    .gap_len   (gap_len),
    .trig_dly  (trig_dly),
    .strobe    (strobe),
    .win_close (win_close),
    .trig_drop (trig_drop)
  );

  strb_event_counters #(.FRAME_W(FRAME_W), .DROP_W(DROP_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .win_close (win_close),
    .trig_drop (trig_drop),
    .rd_start  (rd_start),
    .frame_cnt (frame_cnt),
    .drop_cnt  (drop_cnt)
  );

  strb_pixel_latch #(.NPIX(NPIX)) u_pix (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .hit_pulse (hit_pulse),
    .held      (pix_latched)
  );

  // R4: readout starts only on the falling edge of the strobe
  a_r4_rd_on_fall: assert property (@(posedge clk) disable iff (rst)
    rd_start |-> $fell(strobe));

  // R4: a readout pulse never lasts two cycles
  a_r4_rd_single: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> !rd_start);

endmodule

// File: tb/sim_strobe_sequencer.sv
`timescale 1ns/100ps
module sim_strobe_sequencer;

  localparam real CLK_NS = 25.0;
  localparam int  NPIX   = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        mode_cont;
  logic        trig;
  logic [7:0]  win_len;
  logic [7:0]  gap_len;
  logic [7:0]  trig_dly;
  logic [NPIX-1:0] hit_pulse;
  logic        strobe;
  logic        rd_start;
  logic [15:0] frame_cnt;
  logic [7:0]  drop_cnt;
  logic [NPIX-1:0] pix_latched;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // {win_len, gap_len, trig_dly}
  localparam logic [23:0] SHOTS [6] = '{
    {8'd4,  8'd4, 8'd0},
    {8'd1,  8'd2, 8'd3},
    {8'd0,  8'd1, 8'd0},
    {8'd7,  8'd0, 8'd2},
    {8'd3,  8'd5, 8'd1},
    {8'd10, 8'd4, 8'd5}
  };

  always #(CLK_NS / 2.0) clk = ~clk;

  strobe_sequencer u0 (
    .clk(clk), .rst(rst), .mode_cont(mode_cont), .trig(trig),
    .win_len(win_len), .gap_len(gap_len), .trig_dly(trig_dly),
    .hit_pulse(hit_pulse), .strobe(strobe), .rd_start(rd_start),
    .frame_cnt(frame_cnt), .drop_cnt(drop_cnt), .pix_latched(pix_latched)
  );

  function automatic int min_one(input int v);
    if (v < 1) return 1;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int rise_k, width, rd_k, rd_n, fr0, dr0, nrise;
    int rises[4];
    rst = 1; mode_cont = 0; trig = 0; win_len = 4; gap_len = 4; trig_dly = 0; hit_pulse = '0;
    settle(3);
    // R1: reset state
    chk("R1 strobe", int'(strobe), 0);
    chk("R1 rd_start", int'(rd_start), 0);
    chk("R1 frame_cnt", int'(frame_cnt), 0);
    chk("R1 drop_cnt", int'(drop_cnt), 0);
    chk("R1 pix_latched", int'(pix_latched), 0);
    rst = 0;
    settle(2);

    // R2 R4 R5: table of single triggered shots
    for (int i = 0; i < 6; i++) begin
      int w, g, d;
      w = int'(SHOTS[i][23:16]); g = int'(SHOTS[i][15:8]); d = int'(SHOTS[i][7:0]);
      win_len = 8'(w); gap_len = 8'(g); trig_dly = 8'(d);
      fr0 = int'(frame_cnt);
      trig = 1; @(negedge clk); trig = 0;
      rise_k = -1; width = 0; rd_k = -1; rd_n = 0;
      for (int k = 1; k <= 40; k++) begin
        if (strobe) begin if (rise_k < 0) rise_k = k; width++; end
        if (rd_start) begin if (rd_k < 0) rd_k = k; rd_n++; end
        @(negedge clk);
      end
      chk("R2 rise cycle", rise_k, d + 1);
      chk("R2 window width", width, min_one(w));
      chk("R4 rd_start cycle", rd_k, d + min_one(w) + 1);
      chk("R4 rd_start pulses", rd_n, 1);
      chk("R5 frame step", int'(frame_cnt) - fr0, 1);
    end

    // R10 R6: trigger in last gap cycle dropped, first idle cycle accepted
    win_len = 3; gap_len = 4; trig_dly = 0;
    dr0 = int'(drop_cnt);
    trig = 1; @(negedge clk); trig = 0;
    for (int k = 1; k <= 9; k++) begin
      if (k == 7) trig = 1;
      if (k == 8) chk("R10 low at k8", int'(strobe), 0);
      if (k == 9) begin
        trig = 0;
        chk("R10 reopen at k9", int'(strobe), 1);
      end
      @(negedge clk);
    end
    chk("R6 gap trigger counted", int'(drop_cnt) - dr0, 1);
    settle(20);

    // R6: triggers during delay and window
    win_len = 5; gap_len = 1; trig_dly = 3;
    dr0 = int'(drop_cnt);
    trig = 1; @(negedge clk); trig = 0;
    rd_n = 0; width = 0;
    for (int k = 1; k <= 30; k++) begin
      trig = (k == 2 || k == 6);
      if (strobe) width++;
      if (rd_start) rd_n++;
      @(negedge clk);
    end
    trig = 0;
    chk("R6 busy drops", int'(drop_cnt) - dr0, 2);
    chk("R6 one window only", width, 5);
    chk("R6 one readout only", rd_n, 1);

    // R8: capture depends on overlap with strobe
    win_len = 4; gap_len = 2; trig_dly = 0;
    hit_pulse = 4'b0010; trig = 1; @(negedge clk); trig = 0;
    for (int k = 1; k <= 6; k++) begin
      case (k)
        1: hit_pulse = 4'b0001;
        4: hit_pulse = 4'b0100;
        5: hit_pulse = 4'b1000;
        default: hit_pulse = 4'b0000;
      endcase
      @(negedge clk);
    end
    hit_pulse = '0;
    chk("R8 captured set", int'(pix_latched), 5);
    settle(5);
    chk("R8 held after gap", int'(pix_latched), 5);
    trig = 1; @(negedge clk); trig = 0;
    settle(8);
    chk("R8 cleared by next window", int'(pix_latched), 0);

    // R3 R7 R9: continuous mode with zero gap, then switch back
    win_len = 5; gap_len = 0;
    dr0 = int'(drop_cnt);
    mode_cont = 1; @(negedge clk);
    nrise = 0; width = 0;
    for (int k = 1; k <= 40; k++) begin
      trig = (k == 3 || k == 8);
      if (k == 15) mode_cont = 0;
      if (strobe && nrise < 4 && (k == 1 || width == 0)) begin rises[nrise] = k; nrise++; end
      if (k == 17) chk("R9 window runs on", int'(strobe), 1);
      if (k >= 19 && strobe) chk("R9 no window after switch", k, 0);
      width = strobe ? width + 1 : 0;
      @(negedge clk);
    end
    trig = 0;
    chk("R3 first rise", rises[0], 1);
    chk("R3 second rise", rises[1], 7);
    chk("R3 third rise", rises[2], 13);
    chk("R7 no drop in continuous", int'(drop_cnt) - dr0, 0);

    // R3: continuous with nonzero gap
    win_len = 1; gap_len = 3;
    mode_cont = 1; @(negedge clk);
    nrise = 0;
    for (int k = 1; k <= 8; k++) begin
      if (strobe && nrise < 4) begin rises[nrise] = k; nrise++; end
      @(negedge clk);
    end
    mode_cont = 0;
    chk("R3 gap period count", nrise, 2);
    chk("R3 gap period second", rises[1], 5);
    settle(10);

    // R1: mid-window reset
    win_len = 8; gap_len = 2; trig_dly = 0;
    hit_pulse = 4'b1111; trig = 1; @(negedge clk); trig = 0;
    settle(3);
    rst = 1; @(negedge clk); rst = 0; hit_pulse = '0;
    chk("R1 reset strobe", int'(strobe), 0);
    chk("R1 reset frame", int'(frame_cnt), 0);
    chk("R1 reset drops", int'(drop_cnt), 0);
    chk("R1 reset latch", int'(pix_latched), 0);
    chk("R1 reset rd_start", int'(rd_start), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule